// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes in frames that a keyboard sends over a two-wire link, a clock line and a data line, both driven by the keyboard. Each line is brought into the system clock through a flop synchroniser. The keyboard clock also passes through a glitch filter, and the rising edges of the filtered clock are detected. On each rising edge the data line is sampled. A frame holds a start bit, which is low, then eight data bits with the least significant bit first, then one odd-parity bit. After the parity bit the keyboard pulls the data line low to mark the end of the frame.

A complete byte is placed in a one-deep hold register and offered on a valid/ready interface. There are three kinds of failure: a start bit that is not low, a parity mismatch, and a missing stop indication or stalled keyboard clock. On any failure the receiver returns to its rest state and clears its partial state. It then pulses an error output and a request for the transmit side to send the resend code. The host can hold the keyboard off through an inhibit input, which drives an open-drain pull-down enable on the data line.

The frame controller has four states:
- `S_REST`: idle, and also the reset state.
- `S_DATA`: shifting in the data bits.
- `S_PARITY`: waiting for the parity edge.
- `S_TAIL`: waiting for the data line to go low.

Its transitions are:
- `S_REST` to `S_DATA` on a rising edge with data low.
- `S_REST` stays in `S_REST` on a rising edge with data high; this is a framing fault.
- `S_DATA` to `S_PARITY` on the rising edge that carries data bit 7.
- `S_PARITY` to `S_TAIL` on a rising edge with correct parity.
- `S_PARITY` to `S_REST` on a rising edge with wrong parity; this is a parity fault.
- `S_TAIL` to `S_REST` when data goes low; the byte is delivered.
- `S_DATA`, `S_PARITY` and `S_TAIL` each go to `S_REST` on timeout; this is a framing fault.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset the receiver is in its rest state. `rx_valid_o` is 0, no error, resend or overrun pulse is given, and `kb_data_pull_o` follows `inhibit_i`.
- R2: A frame is a low start bit, then data bits 0 to 7 least significant bit first, then the parity bit. A correct frame delivers its byte on `rx_data_o` with bit 0 equal to the first data bit sent.
- R3: Bits are sampled on rising edges of the keyboard clock after filtering. A low or high pulse on `kb_clk_i` lasting fewer than FILT_LEN system cycles produces no edge.
- R4: If the data line is high at the first rising edge of a frame, `frame_err_o` and `resend_req_o` pulse and no byte is delivered.
- R5: Parity is odd: the eight data bits plus the parity bit must hold an odd number of ones. Otherwise `parity_err_o` and `resend_req_o` pulse and no byte is delivered.
- R6: After the parity edge the data line must go low before the timeout. If it does not, `frame_err_o` and `resend_req_o` pulse and no byte is delivered.
- R7: If the next rising edge inside a frame does not arrive within TIMEOUT_CYC cycles, the receiver returns to rest with a framing error. A following correct frame is then received normally.
- R8: A start bit whose low phase is many times longer than a normal bit is accepted.
- R9: While `rx_valid_o` is 1 and `rx_ready_i` is 0, `rx_valid_o` stays 1 and `rx_data_o` holds its value. A byte is consumed in a cycle where both are 1.
- R10: If a byte completes while an unread byte is held, `overrun_o` pulses, the held byte is kept and the new byte is dropped.
- R11: `frame_err_o`, `parity_err_o` and `resend_req_o` are one-cycle pulses. `resend_req_o` pulses once for each error, and `resend_code_o` reads 0xFE.
- R12: `kb_data_pull_o` is 1 exactly while `inhibit_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_data_i | input | 1 | Keyboard data line, asynchronous |
| inhibit_i | input | 1 | Host request to hold the keyboard off |
| kb_data_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the byte |
| overrun_o | output | 1 | Pulse: byte dropped because the hold register was full |
| frame_err_o | output | 1 | Pulse: bad start bit, missing stop or timeout |
| parity_err_o | output | 1 | Pulse: odd-parity check failed |
| resend_req_o | output | 1 | Pulse: ask the transmit side to send the resend code |
| resend_code_o | output | 8 | Resend code value (0xFE) |

## Verification
The bytes 0x01 and 0x80 are mirror images of each other, so sending both shows whether bit order is wrong. A pattern such as 0xA5 catches bit slips and parity mistakes in the middle of a byte. A stretched start bit and a one-cycle clock glitch inside a bit show that edges are counted only on real, filtered rising edges. Separate frames with a high start bit, inverted parity, a missing stop low and a keyboard clock that stalls mid-frame each lead to one particular error pulse. A correct frame after each fault shows the receiver recovers. Two frames sent while the consumer is stalled separate the hold-and-keep behaviour from the overrun drop.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    typedef enum logic [1:0] {
        S_REST   = 2'd0,
        S_DATA   = 2'd1,
        S_PARITY = 2'd2,
        S_TAIL   = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_DONE   = 2'd1,
        EV_FRAME  = 2'd2,
        EV_PARITY = 2'd3
    } rx_event_t;

endpackage

// File: rtl/kbd_line_cond.sv
// Synchronises both keyboard lines, filters the clock line and flags its
// rising edges together with the data level present at that edge.
module kbd_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_clk_i,
    input  logic kb_data_i,
    output logic rise_o,
    output logic data_o
);
    localparam int FW = $clog2(FILT_LEN + 1);
    localparam logic [FW-1:0] FILT_LAST = FW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] clk_sh;
    logic [SYNC_STAGES-1:0] dat_sh;
    logic                   clk_s;
    logic                   filt_q;
    logic                   filt_d;
    logic [FW-1:0]          filt_cnt;

    // Idle level of both lines is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh <= '1;
            dat_sh <= '1;
        end else begin
            clk_sh <= {clk_sh[SYNC_STAGES-2:0], kb_clk_i};
            dat_sh <= {dat_sh[SYNC_STAGES-2:0], kb_data_i};
        end
    end

    assign clk_s  = clk_sh[SYNC_STAGES-1];
    assign data_o = dat_sh[SYNC_STAGES-1];

    // Filtered level moves only after FILT_LEN consecutive disagreeing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q   <= 1'b1;
            filt_cnt <= '0;
        end else if (clk_s == filt_q) begin
            filt_cnt <= '0;
        end else if (filt_cnt == FILT_LAST) begin
            filt_q   <= clk_s;
            filt_cnt <= '0;
        end else begin
            filt_cnt <= filt_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_d <= 1'b1;
        else        filt_d <= filt_q;
    end

    assign rise_o = filt_q & ~filt_d;

    // Filtered edges are at least FILT_LEN cycles apart.
    assert_rise_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("rise pulse wider than one cycle");

endmodule

// File: rtl/kbd_rx_fsm.sv
// Frame controller: start check, LSB-first shift, odd parity, stop wait,
// inter-edge timeout.
module kbd_rx_fsm
    import kbd_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_done_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              resend_o
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(DATA_W - 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

    rx_state_t         state, state_n;
    rx_event_t         ev;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic [CW-1:0]     bit_cnt;
    logic [TW-1:0]     timer;
    logic              timeout;
    logic              bit_last;

    assign timeout  = (timer == TMO_LAST);
    assign bit_last = (bit_cnt == BIT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_REST;
        else        state <= state_n;
    end

    // Next state and frame event
    always_comb begin
        state_n = state;
        ev      = EV_NONE;
        unique case (state)
            S_REST: begin
                if (rise_i) begin
                    if (!din_i) state_n = S_DATA;
                    else        ev      = EV_FRAME;
                end
            end
            S_DATA: begin
                if (timeout) begin
                    state_n = S_REST;
                    ev      = EV_FRAME;
                end else if (rise_i && bit_last) begin
                    state_n = S_PARITY;
                end
            end
            S_PARITY: begin
                if (timeout) begin
                    state_n = S_REST;
                    ev      = EV_FRAME;
                end else if (rise_i) begin
                    if (par_acc ^ din_i) begin
                        state_n = S_TAIL;
                    end else begin
                        state_n = S_REST;
                        ev      = EV_PARITY;
                    end
                end
            end
            S_TAIL: begin
                if (timeout) begin
                    state_n = S_REST;
                    ev      = EV_FRAME;
                end else if (!din_i) begin
                    state_n = S_REST;
                    ev      = EV_DONE;
                end
            end
            default: state_n = S_REST;
        endcase
    end

    // Datapath: shift register, parity accumulator, bit counter, timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            par_acc <= 1'b0;
            bit_cnt <= '0;
            timer   <= '0;
        end else begin
            if (state == S_REST || rise_i) timer <= '0;
            else                           timer <= timer + 1'b1;

            if (ev == EV_FRAME || ev == EV_PARITY) begin
                shreg   <= '0;
                par_acc <= 1'b0;
                bit_cnt <= '0;
            end else if (state == S_REST && rise_i && !din_i) begin
                shreg   <= '0;
                par_acc <= 1'b0;
                bit_cnt <= '0;
            end else if (state == S_DATA && rise_i) begin
                shreg   <= {din_i, shreg[DATA_W-1:1]};
                par_acc <= par_acc ^ din_i;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_done_o  <= 1'b0;
            frame_err_o  <= 1'b0;
            parity_err_o <= 1'b0;
            resend_o     <= 1'b0;
        end else begin
            byte_done_o  <= (ev == EV_DONE);
            frame_err_o  <= (ev == EV_FRAME);
            parity_err_o <= (ev == EV_PARITY);
            resend_o     <= (ev == EV_FRAME) || (ev == EV_PARITY);
        end
    end

    assign byte_o = shreg;

    assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_done_o, frame_err_o, parity_err_o}))
        else $error("more than one frame event at once");

    assert_ferr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o)
        else $error("frame error wider than one cycle");

    assert_err_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_o || parity_err_o) |-> (state == S_REST))
        else $error("receiver not at rest after fault");

endmodule

// File: rtl/kbd_byte_hold.sv
// One-deep output register with valid/ready and overrun drop.
module kbd_byte_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              byte_done_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    input  logic              ready_i,
    output logic              overrun_o
);
    logic load;
    logic take;

    assign take = valid_o & ready_i;
    assign load = byte_done_i & (~valid_o | ready_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o    <= '0;
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            if (load) begin
                data_o  <= byte_i;
                valid_o <= 1'b1;
            end else if (take) begin
                valid_o <= 1'b0;
            end
            overrun_o <= byte_done_i & valid_o & ~ready_i;
        end
    end

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)))
        else $error("held byte changed before consumption");

    assert_overrun_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> valid_o)
        else $error("overrun without a held byte");

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          FILT_LEN    = 4,
    parameter int          TIMEOUT_CYC = 500000,
    parameter logic [7:0]  RESEND_CODE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_clk_i,
    input  logic              kb_data_i,
    input  logic              inhibit_i,
    output logic              kb_data_pull_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_ready_i,
    output logic              overrun_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              resend_req_o,
    output logic [7:0]        resend_code_o
);
    logic              rise;
    logic              din;
    logic [DATA_W-1:0] shifted;
    logic              done;

    assign kb_data_pull_o = inhibit_i;
    assign resend_code_o  = RESEND_CODE;

    kbd_line_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_clk_i (kb_clk_i),
        .kb_data_i(kb_data_i),
        .rise_o   (rise),
        .data_o   (din)
    );

    kbd_rx_fsm #(
        .DATA_W     (DATA_W),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .din_i       (din),
        .byte_o      (shifted),
        .byte_done_o (done),
        .frame_err_o (frame_err_o),
        .parity_err_o(parity_err_o),
        .resend_o    (resend_req_o)
    );

    kbd_byte_hold #(
        .DATA_W(DATA_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (shifted),
        .byte_done_i(done),
        .data_o     (rx_data_o),
        .valid_o    (rx_valid_o),
        .ready_i    (rx_ready_i),
        .overrun_o  (overrun_o)
    );

    assert_resend_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req_o |-> (frame_err_o || parity_err_o))
        else $error("resend request without an error");

endmodule

// File: tb/tb_kbd_frame_rx.sv
module tb_kbd_frame_rx;
    localparam int LOW  = 10;
    localparam int HIGH = 20;
    localparam int TMO  = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic       inhibit = 1'b0;
    logic       ready = 1'b1;
    logic       pull;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       ovr, ferr, perr, rsnd;
    logic [7:0] rcode;

    int n_checks = 0;
    int n_fail   = 0;
    int n_ferr = 0, n_perr = 0, n_rsnd = 0, n_ovr = 0, n_wide = 0, n_pop = 0;
    logic pf = 1'b0, pp = 1'b0, pr = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    kbd_frame_rx #(.FILT_LEN(3), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kclk), .kb_data_i(kdat),
        .inhibit_i(inhibit), .kb_data_pull_o(pull),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(ready),
        .overrun_o(ovr), .frame_err_o(ferr), .parity_err_o(perr),
        .resend_req_o(rsnd), .resend_code_o(rcode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ferr) n_ferr++;
            if (perr) n_perr++;
            if (rsnd) n_rsnd++;
            if (ovr)  n_ovr++;
            if ((ferr && pf) || (perr && pp) || (rsnd && pr)) n_wide++;
            pf = ferr; pp = perr; pr = rsnd;
            if (rx_valid && ready) begin
                n_pop++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected byte", int'(rx_data), 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    chk(rx_data == e, "R2", "received byte", int'(rx_data), int'(e));
                end
            end
        end
    end

    task automatic kb_bit(input logic b, input bit glitch);
        kclk = 1'b0;
        kdat = b;
        repeat (LOW) @(negedge clk);
        kclk = 1'b1;
        if (glitch) begin
            repeat (8) @(negedge clk);
            kclk = 1'b0;
            @(negedge clk);
            kclk = 1'b1;
            repeat (HIGH - 9) @(negedge clk);
        end else begin
            repeat (HIGH) @(negedge clk);
        end
    endtask

    // Driver: sends one frame, pushes the expected byte when it should arrive
    task automatic send_frame(input logic [7:0] d, input int start_low,
                              input bit bad_start, input bit bad_par,
                              input bit bad_stop, input bit glitch,
                              input bit expect_byte);
        if (expect_byte) exp_q.push_back(d);
        kclk = 1'b0;
        kdat = bad_start;
        repeat (start_low) @(negedge clk);
        kclk = 1'b1;
        repeat (HIGH) @(negedge clk);
        if (bad_start) begin
            kdat = 1'b1;
            repeat (40) @(negedge clk);
            return;
        end
        for (int i = 0; i < 8; i++) kb_bit(d[i], glitch && (i == 3));
        kb_bit((~^d) ^ bad_par, 1'b0);
        if (bad_stop) begin
            kdat = 1'b1;
            repeat (TMO + 60) @(negedge clk);
        end else begin
            kdat = 1'b0;
            repeat (6) @(negedge clk);
            kdat = 1'b1;
            repeat (30) @(negedge clk);
        end
    endtask

    task automatic counts(input string req, input int ef, input int ep, input int eo);
        chk(n_ferr == ef, req, "frame error count", n_ferr, ef);
        chk(n_perr == ep, req, "parity error count", n_perr, ep);
        chk(n_ovr == eo, req, "overrun count", n_ovr, eo);
        chk(n_rsnd == ef + ep, "R11", "resend count", n_rsnd, ef + ep);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 reset state
        chk(rx_valid == 1'b0, "R1", "valid after reset", int'(rx_valid), 0);
        chk(pull == 1'b0, "R1", "pull after reset", int'(pull), 0);
        counts("R1", 0, 0, 0);
        chk(rcode == 8'hFE, "R11", "resend code", int'(rcode), 'hFE);

        // R12 inhibit
        inhibit = 1'b1;
        #1;
        chk(pull == 1'b1, "R12", "pull with inhibit", int'(pull), 1);
        inhibit = 1'b0;
        #1;
        chk(pull == 1'b0, "R12", "pull released", int'(pull), 0);
        @(negedge clk);

        // R2 normal frames and bit order
        send_frame(8'hA5, LOW, 0, 0, 0, 0, 1);
        send_frame(8'h01, LOW, 0, 0, 0, 0, 1);
        send_frame(8'h80, LOW, 0, 0, 0, 0, 1);
        counts("R2", 0, 0, 0);
        chk(n_pop == 3, "R2", "bytes delivered", n_pop, 3);

        // R8 stretched start bit
        send_frame(8'h3C, 11 * LOW, 0, 0, 0, 0, 1);
        chk(n_pop == 4, "R8", "stretched start byte", n_pop, 4);

        // R3 glitch on the keyboard clock
        send_frame(8'h5A, LOW, 0, 0, 0, 1, 1);
        chk(n_pop == 5, "R3", "glitch frame byte", n_pop, 5);
        counts("R3", 0, 0, 0);

        // R4 bad start bit
        send_frame(8'h00, LOW, 1, 0, 0, 0, 0);
        counts("R4", 1, 0, 0);

        // R5 parity error
        send_frame(8'h77, LOW, 0, 1, 0, 0, 0);
        counts("R5", 1, 1, 0);

        // R6 missing stop indication (parity bit of 0x00 is 1)
        send_frame(8'h00, LOW, 0, 0, 1, 0, 0);
        counts("R6", 2, 1, 0);
        chk(n_pop == 5, "R6", "no byte after fault", n_pop, 5);

        // R7 stalled clock mid-frame, then recovery
        kclk = 1'b0; kdat = 1'b0;
        repeat (LOW) @(negedge clk);
        kclk = 1'b1;
        repeat (HIGH) @(negedge clk);
        kb_bit(1'b1, 1'b0);
        kb_bit(1'b0, 1'b0);
        kdat = 1'b1;
        repeat (TMO + 60) @(negedge clk);
        counts("R7", 3, 1, 0);
        send_frame(8'hC3, LOW, 0, 0, 0, 0, 1);
        chk(n_pop == 6, "R7", "recovery byte", n_pop, 6);

        // R9 hold under backpressure, R10 overrun
        ready = 1'b0;
        send_frame(8'h11, LOW, 0, 0, 0, 0, 1);
        chk(rx_valid == 1'b1, "R9", "valid held", int'(rx_valid), 1);
        chk(rx_data == 8'h11, "R9", "data held", int'(rx_data), 'h11);
        send_frame(8'h22, LOW, 0, 0, 0, 0, 0);
        counts("R10", 3, 1, 1);
        chk(rx_data == 8'h11, "R10", "old byte kept", int'(rx_data), 'h11);
        ready = 1'b1;
        repeat (5) @(negedge clk);
        chk(rx_valid == 1'b0, "R10", "new byte dropped", int'(rx_valid), 0);
        chk(n_pop == 7, "R9", "held byte consumed", n_pop, 7);

        // R11 pulse widths and scoreboard drained
        chk(n_wide == 0, "R11", "wide pulses", n_wide, 0);
        chk(exp_q.size() == 0, "R2", "pending expected bytes", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end
endmodule